// File: doc/BRIEF.md
# Serial-Programmed Wiper Controller

This block holds the wiper setting of a resistor-ladder potentiometer and drives the ladder's switch controls. A host writes a new setting over a three-wire serial port: an active-low select, a serial clock and a data line. While the select is low, each serial-clock rise shifts in one bit, most significant bit first. When the select returns high, the word moves into the wiper latch. The analog ladder itself is not part of the block. Only the one-hot tap enables and the top-terminal connect signal are produced.

A parameter picks between two ladders. The wide ladder has 256 taps and uses an 8-bit word. The narrow ladder has 33 taps and uses a 6-bit word. In the narrow ladder, codes above 32 saturate to the top tap. Both ladders start from midscale after reset. An active-low shutdown input opens the top terminal and leaves only the wiper-to-bottom switch closed. The stored code is kept, and serial writes are still accepted during shutdown. When shutdown is released, the latched code drives the taps again.

The serial inputs and the shutdown input are sampled on the block clock. Serial-clock and select edges are found by comparing each sample with the one taken a cycle earlier.

Top module: `dpot_ctrl`

## Requirements
- R1: While `cs_n` is low, each detected rise of `sclk` shifts `sdi` into the shift register from the bottom, so the word arrives most significant bit first. Only the last W bits before `cs_n` rises are kept, where W is 8 in the wide ladder and 6 in the narrow one.
- R2: A detected rise of `cs_n` copies the shift register into the wiper latch. `code_q` shows the new value one clock after the clock edge that sees the rise. At no other time does `code_q` change, apart from reset.
- R3: While `cs_n` is high, `sclk` edges leave the shift register unchanged.
- R4: Reset sets `code_q` to midscale, which is 128 in the wide ladder and 16 in the narrow one, and clears the shift register to zero.
- R5: In the narrow ladder, latch codes 33 to 63 enable tap 32. `code_q` still holds the raw code.
- R6: In the wide ladder, a latch code c enables tap c (bit c of `tap_en`), for every c from 0 to 255.
- R7: While shutdown is in effect (one clock after `shdn_n` is sampled low), `top_conn` is low and `tap_en` has only bit 0 set, which is the wiper-to-bottom short. The latch keeps its value.
- R8: Serial writes update the latch during shutdown. One clock after `shdn_n` is sampled high again, `tap_en` follows the current latch code.
- R9: Outside shutdown, `top_conn` is high and exactly one bit of `tap_en` is set.
- R10: `tap_en` changes only when the latch updates or when shutdown starts or ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (models power-on) |
| cs_n | input | 1 | Serial select, active low; its rise loads the latch |
| sclk | input | 1 | Serial clock; rising edges shift data |
| sdi | input | 1 | Serial data in, most significant bit first |
| shdn_n | input | 1 | Shutdown request, active low |
| code_q | output | W (8 or 6) | Wiper latch contents |
| tap_en | output | TAPS (256 or 33) | One-hot tap-switch enables; bit 0 is the bottom tap |
| top_conn | output | 1 | Top-terminal switch enable; low in shutdown |

## Verification
The assertions assume that `cs_n`, `sclk`, `sdi` and `shdn_n` are synchronous to `clk`, and that each level is held for at least one clock, so every serial-clock and select edge is seen exactly once. The bench changes all inputs only on falling clock edges. It holds each serial-clock level for one full clock, so no edge can be missed or seen twice. The shutdown assertions apply to the registered shutdown state, so a change on `shdn_n` counts only from the clock after it is sampled.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  // Tap selected by a latch code on a ladder whose highest tap is top_tap.
  function automatic int unsigned tap_of(input int unsigned code,
                                         input int unsigned top_tap);
    return (code > top_tap) ? top_tap : code;
  endfunction

  // Midscale preset: half the number of taps.
  function automatic int unsigned mid_of(input int unsigned taps);
    return taps / 2;
  endfunction

endpackage

// File: rtl/dpot_shifter.sv
module dpot_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic [W-1:0] shift_q,
  output logic         load_evt
);

  logic sclk_d;
  logic cs_d;
  logic shift_evt;

  assign shift_evt = sclk & ~sclk_d & ~cs_n;
  assign load_evt  = cs_n & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      shift_q <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (shift_evt) shift_q <= {shift_q[W-2:0], sdi};
    end
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shift_q == {$past(shift_q[W-2:0]), $past(sdi)});

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt) |=> $stable(shift_q));

endmodule

// File: rtl/dpot_latch.sv
module dpot_latch #(
  parameter int          W   = 8,
  parameter int unsigned MID = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_evt,
  input  logic [W-1:0] shift_in,
  output logic [W-1:0] code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= W'(MID);
    else if (load_evt) code_q <= shift_in;
  end

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> code_q == $past(shift_in));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt) |=> $stable(code_q));

endmodule

// File: rtl/dpot_decoder.sv
module dpot_decoder #(
  parameter int W    = 8,
  parameter int TAPS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shdn_n,
  input  logic [W-1:0]    code,
  output logic [TAPS-1:0] tap_en,
  output logic            top_conn
);
  import dpot_pkg::*;

  localparam int unsigned TOP = TAPS - 1;

  logic        shut_q;
  int unsigned sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_q <= 1'b0;
    else        shut_q <= ~shdn_n;
  end

  assign sel      = tap_of(32'(code), TOP);
  assign top_conn = ~shut_q;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_bot
      assign tap_en[i] = shut_q | (sel == 32'(i));
    end else begin : g_mid
      assign tap_en[i] = ~shut_q & (sel == 32'(i));
    end
  end

  // R9
  one_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q) |-> ($onehot(tap_en) && top_conn));

  // R7
  shut_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |-> (tap_en == TAPS'(1) && !top_conn));

  if (TAPS == 33) begin : g_clamp_chk
    // R5
    clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shut_q && code > W'(32)) |-> tap_en[32]);
  end

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
  parameter bit NARROW = 1'b0,
  localparam int W    = NARROW ? 6 : 8,
  localparam int TAPS = NARROW ? 33 : 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic            shdn_n,
  output logic [W-1:0]    code_q,
  output logic [TAPS-1:0] tap_en,
  output logic            top_conn
);
  import dpot_pkg::*;

  localparam int unsigned MID = mid_of(TAPS);

  logic [W-1:0] shift_q;
  logic         load_evt;

  dpot_shifter #(.W(W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shift_q(shift_q), .load_evt(load_evt)
  );

  dpot_latch #(.W(W), .MID(MID)) latch_i (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .shift_in(shift_q),
    .code_q(code_q)
  );

  dpot_decoder #(.W(W), .TAPS(TAPS)) decoder_i (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .code(code_q),
    .tap_en(tap_en), .top_conn(top_conn)
  );

endmodule

// File: tb/dpot_ctrl_tb_top.sv
module dpot_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic shdn_n = 1'b1;

  logic [7:0]   code8;
  logic [255:0] tap8;
  logic         top8;
  logic [5:0]   code6;
  logic [32:0]  tap6;
  logic         top6;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dpot_ctrl #(.NARROW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn_n(shdn_n), .code_q(code8), .tap_en(tap8), .top_conn(top8)
  );

  dpot_ctrl #(.NARROW(1'b1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn_n(shdn_n), .code_q(code6), .tap_en(tap6), .top_conn(top6)
  );

  // Behavioural reference: shift values kept as bit queues
  bit q8[$];
  bit q6[$];
  int m_code8, m_code6;
  bit m_shut, m_sclk_p, m_cs_p;

  function automatic int q_value(input bit q[$]);
    int v = 0;
    foreach (q[k]) v = v * 2 + int'(q[k]);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q8 = {0, 0, 0, 0, 0, 0, 0, 0};
      q6 = {0, 0, 0, 0, 0, 0};
      m_code8 = 128; m_code6 = 16;
      m_shut = 0; m_sclk_p = 0; m_cs_p = 1;
    end else begin
      if (cs_n && !m_cs_p) begin
        m_code8 = q_value(q8);
        m_code6 = q_value(q6);
      end
      if (sclk && !m_sclk_p && !cs_n) begin
        q8.push_back(sdi); void'(q8.pop_front());
        q6.push_back(sdi); void'(q6.pop_front());
      end
      m_shut = !shdn_n; m_sclk_p = sclk; m_cs_p = cs_n;
    end
  end

  // index of the single set bit, -1 when none, -2 when several
  function automatic int one_idx(input logic [255:0] v);
    int idx = -1;
    for (int k = 0; k < 256; k++) begin
      if (v[k]) idx = (idx == -1) ? k : -2;
    end
    return idx;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10: per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 wide code track", int'(code8), m_code8);
      check("R10 narrow code track", int'(code6), m_code6);
      check("R10 wide tap track", one_idx(tap8),
            m_shut ? 0 : m_code8);
      check("R10 narrow tap track", one_idx({223'b0, tap6}),
            m_shut ? 0 : (m_code6 > 32 ? 32 : m_code6));
      check("R10 top track", int'({top8, top6}), m_shut ? 0 : 3);
    end
  end

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send(input int word, input int nbits);
    @(negedge clk);
    cs_n = 1'b0;
    for (int b = nbits - 1; b >= 0; b--) begin
      sdi = word[b];
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk); cs_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic expect_state(input string req, input int c8, input int t8,
                              input int c6, input int t6);
    check({req, " wide code"}, int'(code8), c8);
    check({req, " wide tap"}, one_idx(tap8), t8);
    check({req, " narrow code"}, int'(code6), c6);
    check({req, " narrow tap"}, one_idx({223'b0, tap6}), t6);
  endtask

  initial begin
    wait_clk(3);
    // R4 midscale preset, R9 one tap and top connected
    expect_state("R4 reset", 128, 128, 16, 16);
    check("R9 top after reset", int'({top8, top6}), 3);
    rst_n = 1'b1;
    wait_clk(2);

    // R4 shift register cleared: empty frame loads zero
    send(0, 0);
    expect_state("R4 cleared shift", 0, 0, 0, 0);

    // R1 MSB first, R6 wide tap
    send(8'h5A, 8);
    expect_state("R1 R6 word 5A", 8'h5A, 8'h5A, 8'h1A, 8'h1A);

    // R1 extra leading bits dropped; R5 narrow 37 saturates
    send(10'h3A5, 10);
    expect_state("R1 R5 long frame", 8'hA5, 8'hA5, 37, 32);

    // R3 clock edges with select high are ignored
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    send(0, 0);
    expect_state("R3 idle clocks", 8'hA5, 8'hA5, 37, 32);

    // R6 top wide tap, R5 narrow 63
    send(8'hFF, 8);
    expect_state("R5 R6 all ones", 255, 255, 63, 32);
    send(8'h20, 8);
    expect_state("R5 code 32", 32, 32, 32, 32);
    send(8'h01, 8);
    expect_state("R6 code 1", 1, 1, 1, 1);

    // R7 shutdown
    shdn_n = 1'b0;
    wait_clk(2);
    expect_state("R7 shutdown", 1, 0, 1, 0);
    check("R7 top open", int'({top8, top6}), 0);

    // R8 write during shutdown, then release
    send(8'hC3, 8);
    expect_state("R8 write in shutdown", 8'hC3, 0, 3, 0);
    check("R8 top still open", int'({top8, top6}), 0);
    shdn_n = 1'b1;
    wait_clk(2);
    expect_state("R8 release", 8'hC3, 8'hC3, 3, 3);
    check("R9 top restored", int'({top8, top6}), 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_clk(20000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule